// File: doc/BRIEF.md
# Block-Lookahead Binary Adder

This block adds two unsigned operands and a carry-in, producing a sum of the same width and a carry-out. It has no clock and no registers: the outputs follow the inputs through combinational logic only. The datapath is split into equal slices. Inside each slice every carry is formed in one flat sum-of-products level from that slice's per-bit generate and propagate terms and the slice's incoming carry. Between slices the carry is handed from one slice to the next higher slice.

Each bit first forms a generate term, the AND of its operand bits, and a propagate term, the inclusive OR of its operand bits. A slice's internal carries come from those terms in expanded form, so no carry chain exists inside a slice. Each sum bit is the XOR of its two operand bits and the carry into that bit. The default build is 32 bits wide, made of four 8-bit slices. The total width must be a whole multiple of the slice width.

Top module: `blk_lookahead_adder`

## Requirements
- R1: A bit position whose two operand bits are both 1 sends a carry into the next higher position, whatever carry it receives.
- R2: A bit position whose two operand bits are both 0 sends no carry into the next higher position, whatever carry it receives.
- R3: A bit position with exactly one operand bit set passes its incoming carry unchanged to the next higher position.
- R4: Each sum bit equals operand bit a XOR operand bit b XOR the carry into that position.
- R5: The carry into the lowest bit of each slice (bit positions that are multiples of the slice width) equals the arithmetic carry out of all lower bits, so a carry crosses every slice boundary.
- R6: The external carry-in enters bit 0, and the carry-out is the carry out of the top bit of the top slice.
- R7: {co, sum} equals the arithmetic sum a + b + ci taken one bit wider than the operands, for every input combination.
- R8: An all-ones operand plus 1 with ci = 0 gives an all-zero sum and co = 1.
- R9: All-ones plus all-ones with ci = 1 gives an all-ones sum and co = 1.
- R10: Both outputs depend only on the present inputs and settle without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | TOTAL_W | First operand |
| b | input | TOTAL_W | Second operand |
| ci | input | 1 | Carry into bit 0 |
| sum | output | TOTAL_W | Sum bits |
| co | output | 1 | Carry out of the top bit |

## Verification
Every result of this adder is due in the same cycle as its stimulus, because no register lies between the ports. The driver applies each operand set on the falling edge of the bench clock and queues the expected 33-bit value. The monitor pops that entry on the next rising edge, half a period later, when the logic has long settled. Only one vector is ever in flight, so the queue order matches the order of the results.

// File: rtl/bla_pkg.sv
package bla_pkg;
  // Per-bit carry generate: both operand bits set.
  function automatic logic gen_bit(input logic x, input logic y);
    return x & y;
  endfunction

  // Per-bit carry propagate: inclusive OR of the operand bits.
  function automatic logic prop_bit(input logic x, input logic y);
    return x | y;
  endfunction

  // Sum bit from operands and incoming carry.
  function automatic logic sum_bit(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction
endpackage

// File: rtl/bla_gp_slice.sv
module bla_gp_slice #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  import bla_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]  = gen_bit(a[i], b[i]);
    assign prop[i] = prop_bit(a[i], b[i]);
  end
endmodule

// File: rtl/bla_cla_block.sv
module bla_cla_block #(
  parameter int unsigned BW = 8
) (
  input  logic [BW-1:0] gen,
  input  logic [BW-1:0] prop,
  input  logic          cin,
  output logic [BW-1:0] cout_vec   // carry into local bit j+1 at index j
);
  // Carry into local bit j+1 is the OR of j+2 product terms:
  //   gen[k] AND prop[j..k+1] for k = 0..j, plus prop[j..0] AND cin.
  for (genvar j = 0; j < BW; j++) begin : g_carry
    logic [j+1:0] term;
    for (genvar k = 0; k <= j; k++) begin : g_term
      if (k == j) begin : g_top
        assign term[k] = gen[k];
      end else begin : g_mid
        assign term[k] = gen[k] & (&prop[j:k+1]);
      end
    end
    assign term[j+1]   = (&prop[j:0]) & cin;
    assign cout_vec[j] = |term;
  end
endmodule

// File: rtl/blk_lookahead_adder.sv
module blk_lookahead_adder #(
  parameter int unsigned TOTAL_W = 32,
  parameter int unsigned BLK_W   = 8
) (
  input  logic [TOTAL_W-1:0] a,
  input  logic [TOTAL_W-1:0] b,
  input  logic               ci,
  output logic [TOTAL_W-1:0] sum,
  output logic               co
);
  import bla_pkg::*;

  localparam int unsigned NBLK = TOTAL_W / BLK_W;

  // Named internal events for the checker.
  logic [TOTAL_W-1:0] gen_w;
  logic [TOTAL_W-1:0] prop_w;
  logic [TOTAL_W:0]   carry_w;   // carry_w[i] = carry into bit i

  bla_gp_slice #(.W(TOTAL_W)) u_gp (
    .a    (a),
    .b    (b),
    .gen  (gen_w),
    .prop (prop_w)
  );

  assign carry_w[0] = ci;

  for (genvar n = 0; n < NBLK; n++) begin : g_blk
    bla_cla_block #(.BW(BLK_W)) u_blk (
      .gen      (gen_w[n*BLK_W +: BLK_W]),
      .prop     (prop_w[n*BLK_W +: BLK_W]),
      .cin      (carry_w[n*BLK_W]),
      .cout_vec (carry_w[n*BLK_W+1 +: BLK_W])
    );
  end

  for (genvar i = 0; i < TOTAL_W; i++) begin : g_sum
    assign sum[i] = sum_bit(a[i], b[i], carry_w[i]);
  end

  assign co = carry_w[TOTAL_W];
endmodule

// File: rtl/bla_chk.sv
module bla_chk #(
  parameter int unsigned TOTAL_W = 32,
  parameter int unsigned BLK_W   = 8
) (
  input logic [TOTAL_W-1:0] a,
  input logic [TOTAL_W-1:0] b,
  input logic               ci,
  input logic [TOTAL_W-1:0] sum,
  input logic               co,
  input logic [TOTAL_W:0]   carry_w
);
  localparam int unsigned NBLK = TOTAL_W / BLK_W;

  logic [TOTAL_W:0] ref_w;
  assign ref_w = {1'b0, a} + {1'b0, b} + {{TOTAL_W{1'b0}}, ci};

  always_comb begin
    for (int i = 0; i < TOTAL_W; i++) begin
      AST_GEN_FORCES: assert (!(a[i] && b[i]) || carry_w[i+1]);                 // R1
      AST_ZERO_KILLS: assert (a[i] || b[i] || !carry_w[i+1]);                   // R2
      AST_ONE_PASSES: assert ((a[i] == b[i]) || (carry_w[i+1] == carry_w[i]));  // R3
      AST_SUM_BIT:    assert (sum[i] == ((a[i] != b[i]) != carry_w[i]));        // R4
    end
    for (int n = 1; n < NBLK; n++) begin
      AST_BLK_CARRY: assert (carry_w[n*BLK_W] ==
        (((a & ((TOTAL_W'(1) << (n*BLK_W)) - 1)) +
          (b & ((TOTAL_W'(1) << (n*BLK_W)) - 1)) + TOTAL_W'(ci))
          >> (n*BLK_W)) != 0);                                                  // R5
    end
    AST_CARRY_ENDS: assert (carry_w[0] == ci && co == carry_w[TOTAL_W]);        // R6
    AST_TOTAL:      assert ({co, sum} == ref_w);                                // R7
  end
endmodule

bind blk_lookahead_adder bla_chk #(.TOTAL_W(TOTAL_W), .BLK_W(BLK_W)) u_bla_chk (
  .a       (a),
  .b       (b),
  .ci      (ci),
  .sum     (sum),
  .co      (co),
  .carry_w (carry_w)
);

// File: tb/test_blk_lookahead_adder.sv
module test_blk_lookahead_adder;
  localparam int unsigned TW = 32;
  localparam int unsigned BW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] a = '0, b = '0;
  logic ci = 1'b0;
  logic [TW-1:0] sum;
  logic co;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    logic [TW:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;   // 250 MHz

  blk_lookahead_adder #(.TOTAL_W(TW), .BLK_W(BW)) i_blk_lookahead_adder (
    .a(a), .b(b), .ci(ci), .sum(sum), .co(co)
  );

  // Driver: apply on falling edge, queue the expected value.
  task automatic drive(input logic [TW-1:0] xa, input logic [TW-1:0] xb,
                       input logic xc, input string tag);
    item_t it;
    @(negedge clk);
    a = xa; b = xb; ci = xc;
    it.exp = {1'b0, xa} + {1'b0, xb} + {{TW{1'b0}}, xc};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: result due in the same cycle; sample on the next rising edge.
  always @(posedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_vec++;
      if ({co, sum} !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, {co, sum}, it.exp);
      end
    end
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R10: outputs settle with no clock-driven state; zero inputs held in reset
    #1;
    n_vec++;
    if ({co, sum} !== '0) begin
      n_bad++;
      $display("FAIL R10 reset state: got %h expected 0", {co, sum});
    end
    @(negedge clk);
    rst = 1'b0;

    drive('0, '0, 1'b0, "R10 zero plus zero");
    drive('1, 32'd1, 1'b0, "R8 all-ones plus one");
    drive('1, '1, 1'b1, "R9 all-ones plus all-ones with carry");
    drive('0, '0, 1'b1, "R6 carry-in into bit 0");
    drive('1, '0, 1'b1, "R6 carry-out from full propagate chain");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R6 carry-out from top generate");
    // R1: every bit generates, incoming carry ignored
    drive(32'h5555_5555, 32'h5555_5555, 1'b0, "R1 generate alternating");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R1 generate all bits");
    // R2: both zero kills carry: ones then zero hole
    drive(32'h0000_00F0, 32'h0000_00F0, 1'b1, "R2 zero bits stop carry");
    drive(32'h0F0F_0F0F, 32'h0000_0000, 1'b1, "R2 kill at nibble gaps");
    // R3: exactly one operand bit set passes carry
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R3 propagate complementary");
    drive(32'h0000_FFFF, 32'hFFFF_0000, 1'b1, "R3 propagate split halves");
    // R4: sum bits with no carries
    drive(32'h1234_0000, 32'h0000_5678, 1'b0, "R4 disjoint bits");
    // R5: carry across each slice boundary
    for (int n = 1; n < int'(TW/BW); n++) begin
      drive((TW'(1) << (n*BW)) - 1, TW'(1), 1'b0, "R5 boundary ripple");
      drive((TW'(1) << (n*BW)) - 1, '0, 1'b1, "R5 boundary ripple from carry-in");
      drive(TW'(1) << (n*BW - 1), TW'(1) << (n*BW - 1), 1'b0, "R5 boundary generate");
    end
    // R7: random vectors
    for (int k = 0; k < 400; k++) begin
      drive($urandom, $urandom, 1'($urandom), "R7 random");
    end
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule